// File: doc/BRIEF.md
# Lempel-Ziv Byte Stream Decompressor

This block rebuilds original bytes from a compressed byte stream. Compressed bytes arrive on a byte-wide valid/ready input and are taken apart bit by bit, most significant bit first. The bits form literal tokens and copy tokens. A literal token carries one byte. A copy token replays a run of bytes that were already produced, read from a 512-entry history RAM. Every byte the block emits is also written into that history. The output is a byte-wide valid/ready port, and backpressure on it stalls parsing and replay.

A transfer begins with a `start` pulse. This clears all flags and sweeps the history to zero, which takes one cycle per entry. The compressed stream must close with an end-marker token. The marker produces no output, and any padding that follows it up to the end of the last input byte is discarded. If the input runs out before a marker is found, the block raises `end_err`. A nonzero padding bit raises `pad_err`. After a finish or an error the block refuses input until the next `start`.

The controller has these states:
- `S_CLEAR`: history sweep.
- `S_TAG`: reads the token tag bit.
- `S_LIT`, `S_DISP`, `S_LEN`: collect the token fields.
- `S_EMIT`: offers a literal byte.
- `S_COPY`: replays history bytes.
- `S_PAD`: consumes the trailing padding.
- `S_DONE` and `S_ERR`: terminal states.

The transitions are:
- `S_CLEAR`→`S_TAG` after the last address is written.
- `S_TAG`→`S_LIT` on tag 0 and →`S_DISP` on tag 1.
- `S_LIT`→`S_EMIT` after 8 bits.
- `S_DISP`→`S_LEN` after a nonzero displacement.
- `S_DISP`→`S_PAD` after a zero displacement, or →`S_DONE` if that bit was the final input bit.
- `S_LEN`→`S_COPY` after 4 bits.
- `S_EMIT`→`S_TAG` on a handshake.
- `S_COPY`→`S_TAG` on the handshake of the last byte of the run.
- `S_PAD`→`S_DONE` on a final zero bit.
- Any collecting state→`S_ERR` when it consumes the final input bit too early, and `S_PAD`→`S_ERR` on a one bit.
- Any state→`S_CLEAR` on `start`.

Top module: `lzd_decomp`

## Requirements
- R1: A literal token is a 0 tag bit followed by 8 data bits, most significant first. Bits are taken from each input byte starting at bit 7. The literal emits exactly that byte.
- R2: A copy token is a 1 tag bit, then a 9-bit displacement d (1..511, MSB first), then a 4-bit length code n. It emits n+2 bytes. Each byte is the history byte d positions behind the current write position.
- R3: Every copied byte is written into the history before the next one is read, so a copy with d smaller than its length repeats the last d bytes.
- R4: The write position and the displacement arithmetic wrap modulo 512, so copies across the wrap point return the most recently written data.
- R5: A `start` pulse zeroes the whole history. A copy that reaches positions not yet written in the transfer returns 0x00.
- R6: The end marker is a 1 tag bit followed by nine 0 bits. It emits nothing and sets `done`. Zero padding after it, including whole zero bytes, up to the input byte flagged by `in_last`, is accepted silently.
- R7: If the final bit of the `in_last` byte is consumed anywhere but at the close of an end marker or inside padding, `end_err` is set. The unfinished token is not emitted, and `done` stays 0.
- R8: A 1 bit in the padding after the end marker sets `pad_err`, and `done` stays 0.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold. No byte is lost or repeated.
- R10: Once `done`, `end_err` or `pad_err` is set, it stays set, `in_ready` stays low and no output is produced until the next `start`.
- R11: After reset or `start`, all flags read 0, `out_valid` is 0, and `in_ready` stays low for the 512-cycle history sweep.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new transfer: clear flags and history |
| in_data | input | 8 | Compressed input byte |
| in_valid | input | 1 | Input byte offered |
| in_last | input | 1 | Marks the final compressed byte of the transfer |
| in_ready | output | 1 | Block accepts the offered byte |
| out_data | output | 8 | Decompressed byte |
| out_valid | output | 1 | Decompressed byte offered |
| out_ready | input | 1 | Consumer takes the offered byte |
| done | output | 1 | End marker found and padding clean |
| end_err | output | 1 | Input ended without an end marker |
| pad_err | output | 1 | Nonzero padding after the end marker |

## Verification
A stream of plain literals shows that the bit order and the byte boundaries are right, because the 9-bit tokens straddle input bytes. Copies with several displacements separate correct addressing from off-by-one reads. An overlapping copy under a stalling consumer tells write-before-read apart from a stale read, and shows whether the byte stays stable during the stall. A run longer than 512 bytes, followed by a short copy, shows whether the pointer wraps. A copy straight after `start` shows whether the history was swept. Streams that end in a missing marker, in a set padding bit, and in an extra zero padding byte separate the three ways a transfer can close.

// File: rtl/lzd_pkg.sv
package lzd_pkg;

    typedef enum logic [3:0] {
        S_CLEAR,
        S_TAG,
        S_LIT,
        S_DISP,
        S_LEN,
        S_EMIT,
        S_COPY,
        S_PAD,
        S_DONE,
        S_ERR
    } lzd_state_e;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/lzd_bit_unpack.sv
module lzd_bit_unpack #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          run,
    input  logic [DW-1:0] in_data,
    input  logic          in_valid,
    input  logic          in_last,
    output logic          in_ready,
    input  logic          take,
    output logic          bit_valid,
    output logic          bit_val,
    output logic          bit_last
);
    localparam int CW = $clog2(DW + 1);

    logic [DW-1:0] sh;
    logic [CW-1:0] cnt;
    logic          last_r;

    assign in_ready  = run && (cnt == '0);
    assign bit_valid = (cnt != '0);
    assign bit_val   = sh[DW-1];
    assign bit_last  = last_r && (cnt == CW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh     <= '0;
            cnt    <= '0;
            last_r <= 1'b0;
        end else if (flush) begin
            cnt    <= '0;
            last_r <= 1'b0;
        end else if (in_valid && in_ready) begin
            sh     <= in_data;
            cnt    <= CW'(DW);
            last_r <= in_last;
        end else if (take && bit_valid) begin
            sh     <= {sh[DW-2:0], 1'b0};
            cnt    <= cnt - CW'(1);
        end
    end
endmodule

// File: rtl/lzd_history.sv
module lzd_history #(
    parameter int DEPTH = 512,
    parameter int DW    = 8,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/lzd_token_ctrl.sv
module lzd_token_ctrl
    import lzd_pkg::*;
#(
    parameter int DW      = 8,
    parameter int DEPTH   = 512,
    parameter int LEN_W   = 4,
    parameter int MIN_LEN = 2,
    parameter int AW      = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          bit_valid,
    input  logic          bit_val,
    input  logic          bit_last,
    output logic          take,
    output logic          run,
    output logic          flush,
    output logic          hist_we,
    output logic [AW-1:0] hist_waddr,
    output logic [DW-1:0] hist_wdata,
    output logic [AW-1:0] hist_raddr,
    input  logic [DW-1:0] hist_rdata,
    output logic [DW-1:0] out_data,
    output logic          out_valid,
    input  logic          out_ready,
    output logic          done,
    output logic          end_err,
    output logic          pad_err
);
    localparam int ACC_W = max3(DW, AW, LEN_W);
    localparam int CNT_W = $clog2(ACC_W + 1);
    localparam int REM_W = $clog2((1 << LEN_W) + MIN_LEN);
    localparam logic [AW-1:0]    LAST_ADDR = AW'(DEPTH - 1);
    localparam logic [CNT_W-1:0] LIT_END   = CNT_W'(DW - 1);
    localparam logic [CNT_W-1:0] DISP_END  = CNT_W'(AW - 1);
    localparam logic [CNT_W-1:0] LEN_END   = CNT_W'(LEN_W - 1);

    lzd_state_e state, nxt;

    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] acc_next;
    logic [CNT_W-1:0] bcnt;
    logic [DW-1:0]    lit;
    logic [AW-1:0]    disp;
    logic [REM_W-1:0] remain;
    logic [AW-1:0]    wptr;
    logic             fire;
    logic             field_end;
    logic             emit;

    assign acc_next = {acc[ACC_W-2:0], bit_val};
    assign fire     = take && bit_valid;
    assign emit     = out_valid && out_ready;

    always_comb begin
        unique case (state)
            S_LIT:   field_end = (bcnt == LIT_END);
            S_DISP:  field_end = (bcnt == DISP_END);
            S_LEN:   field_end = (bcnt == LEN_END);
            default: field_end = 1'b0;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_CLEAR;
        end else begin
            state <= nxt;
        end
    end

    // next state
    always_comb begin
        nxt = state;
        if (start) begin
            nxt = S_CLEAR;
        end else begin
            unique case (state)
                S_CLEAR: if (wptr == LAST_ADDR) nxt = S_TAG;
                S_TAG: begin
                    if (fire) begin
                        if (bit_last)     nxt = S_ERR;
                        else if (bit_val) nxt = S_DISP;
                        else              nxt = S_LIT;
                    end
                end
                S_LIT: begin
                    if (fire) begin
                        if (bit_last)       nxt = S_ERR;
                        else if (field_end) nxt = S_EMIT;
                    end
                end
                S_DISP: begin
                    if (fire) begin
                        if (field_end && acc_next[AW-1:0] == '0)
                            nxt = bit_last ? S_DONE : S_PAD;
                        else if (bit_last)
                            nxt = S_ERR;
                        else if (field_end)
                            nxt = S_LEN;
                    end
                end
                S_LEN: begin
                    if (fire) begin
                        if (bit_last)       nxt = S_ERR;
                        else if (field_end) nxt = S_COPY;
                    end
                end
                S_EMIT: if (out_ready) nxt = S_TAG;
                S_COPY: if (out_ready && remain == REM_W'(1)) nxt = S_TAG;
                S_PAD: begin
                    if (fire) begin
                        if (bit_val)       nxt = S_ERR;
                        else if (bit_last) nxt = S_DONE;
                    end
                end
                S_DONE:  nxt = S_DONE;
                S_ERR:   nxt = S_ERR;
                default: nxt = S_ERR;
            endcase
        end
    end

    // outputs
    always_comb begin
        take       = 1'b0;
        run        = 1'b0;
        out_valid  = 1'b0;
        out_data   = hist_rdata;
        flush      = start || (state == S_CLEAR);
        unique case (state)
            S_TAG, S_LIT, S_DISP, S_LEN, S_PAD: begin
                take = bit_valid;
                run  = 1'b1;
            end
            S_EMIT: begin
                run       = 1'b1;
                out_valid = 1'b1;
                out_data  = lit;
            end
            S_COPY: begin
                run       = 1'b1;
                out_valid = 1'b1;
            end
            default: ;
        endcase
        hist_we    = (state == S_CLEAR) || emit;
        hist_waddr = wptr;
        hist_wdata = (state == S_CLEAR) ? '0 : out_data;
        hist_raddr = wptr - disp;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc     <= '0;
            bcnt    <= '0;
            lit     <= '0;
            disp    <= '0;
            remain  <= '0;
            wptr    <= '0;
            done    <= 1'b0;
            end_err <= 1'b0;
            pad_err <= 1'b0;
        end else if (start) begin
            bcnt    <= '0;
            wptr    <= '0;
            done    <= 1'b0;
            end_err <= 1'b0;
            pad_err <= 1'b0;
        end else begin
            if (nxt == S_DONE && state != S_DONE) done <= 1'b1;
            if (nxt == S_ERR && state != S_ERR) begin
                if (state == S_PAD) pad_err <= 1'b1;
                else                end_err <= 1'b1;
            end
            unique case (state)
                S_CLEAR: wptr <= wptr + AW'(1);
                S_LIT, S_DISP, S_LEN: begin
                    if (fire) begin
                        acc  <= acc_next;
                        bcnt <= field_end ? '0 : bcnt + CNT_W'(1);
                        if (field_end) begin
                            if (state == S_LIT)  lit  <= acc_next[DW-1:0];
                            if (state == S_DISP) disp <= acc_next[AW-1:0];
                            if (state == S_LEN)
                                remain <= REM_W'(acc_next[LEN_W-1:0]) + REM_W'(MIN_LEN);
                        end
                    end
                end
                S_EMIT: if (emit) wptr <= wptr + AW'(1);
                S_COPY: begin
                    if (emit) begin
                        wptr   <= wptr + AW'(1);
                        remain <= remain - REM_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/lzd_decomp.sv
module lzd_decomp #(
    parameter int DW      = 8,
    parameter int DEPTH   = 512,
    parameter int LEN_W   = 4,
    parameter int MIN_LEN = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [DW-1:0] in_data,
    input  logic          in_valid,
    input  logic          in_last,
    output logic          in_ready,
    output logic [DW-1:0] out_data,
    output logic          out_valid,
    input  logic          out_ready,
    output logic          done,
    output logic          end_err,
    output logic          pad_err
);
    localparam int AW = $clog2(DEPTH);

    logic          run, flush, take;
    logic          bit_valid, bit_val, bit_last;
    logic          hist_we;
    logic [AW-1:0] hist_waddr, hist_raddr;
    logic [DW-1:0] hist_wdata, hist_rdata;

    lzd_bit_unpack #(.DW(DW)) u_unpack (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .run       (run),
        .in_data   (in_data),
        .in_valid  (in_valid),
        .in_last   (in_last),
        .in_ready  (in_ready),
        .take      (take),
        .bit_valid (bit_valid),
        .bit_val   (bit_val),
        .bit_last  (bit_last)
    );

    lzd_history #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_hist (
        .clk   (clk),
        .we    (hist_we),
        .waddr (hist_waddr),
        .wdata (hist_wdata),
        .raddr (hist_raddr),
        .rdata (hist_rdata)
    );

    lzd_token_ctrl #(
        .DW(DW), .DEPTH(DEPTH), .LEN_W(LEN_W), .MIN_LEN(MIN_LEN), .AW(AW)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .bit_valid  (bit_valid),
        .bit_val    (bit_val),
        .bit_last   (bit_last),
        .take       (take),
        .run        (run),
        .flush      (flush),
        .hist_we    (hist_we),
        .hist_waddr (hist_waddr),
        .hist_wdata (hist_wdata),
        .hist_raddr (hist_raddr),
        .hist_rdata (hist_rdata),
        .out_data   (out_data),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .done       (done),
        .end_err    (end_err),
        .pad_err    (pad_err)
    );
endmodule

// File: rtl/lzd_decomp_chk.sv
module lzd_decomp_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          in_ready,
    input logic [DW-1:0] out_data,
    input logic          out_valid,
    input logic          out_ready,
    input logic          done,
    input logic          end_err,
    input logic          pad_err
);
    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready && !start |=> out_valid && $stable(out_data));

    // R10
    closed_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done || end_err || pad_err) |-> !in_ready && !out_valid);

    // R10
    end_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        end_err && !start |=> end_err);

    // R8
    pad_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pad_err && !start |=> pad_err && !done);

    // R6
    done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !end_err && !pad_err);

    // R11
    start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !done && !end_err && !pad_err && !in_ready && !out_valid);
endmodule

bind lzd_decomp lzd_decomp_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .in_ready  (in_ready),
    .out_data  (out_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .done      (done),
    .end_err   (end_err),
    .pad_err   (pad_err)
);

// File: tb/lzd_decomp_test.sv
module lzd_decomp_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_valid = 1'b0;
    logic       in_last = 1'b0;
    logic       in_ready;
    logic [7:0] out_data;
    logic       out_valid;
    logic       out_ready = 1'b1;
    logic       done, end_err, pad_err;

    lzd_decomp uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .in_data(in_data), .in_valid(in_valid), .in_last(in_last), .in_ready(in_ready),
        .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
        .done(done), .end_err(end_err), .pad_err(pad_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    logic       bitq [0:4095];
    int         nb;
    logic [7:0] stream [0:1023];
    logic [7:0] exp_q [0:1023];
    int         ne;
    logic [7:0] got_q [0:1023];
    int         ng;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic put(input int v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            bitq[nb] = v[i];
            nb++;
        end
    endtask

    task automatic lit(input int b);
        put(0, 1); put(b, 8);
        exp_q[ne] = b[7:0]; ne++;
    endtask

    task automatic cpy(input int d, input int len);
        put(1, 1); put(d, 9); put(len - 2, 4);
    endtask

    task automatic expect_byte(input int b);
        exp_q[ne] = b[7:0]; ne++;
    endtask

    task automatic marker();
        put(1, 1); put(0, 9);
    endtask

    task automatic begin_xfer();
        nb = 0; ne = 0; ng = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        #1;
        // R11: sweep in progress, nothing accepted, flags cleared
        chk(!in_ready && !out_valid && !done && !end_err && !pad_err, "R11 start state",
            {in_ready, out_valid, done, end_err, pad_err}, 0);
    endtask

    task automatic run_stream(input bit bp);
        int nbytes, idx, cyc, hold;
        logic [7:0] hold_d;
        nbytes = (nb + 7) / 8;
        for (int i = 0; i < nbytes; i++) begin
            for (int j = 0; j < 8; j++)
                stream[i][7-j] = (i * 8 + j < nb) ? bitq[i*8+j] : 1'b0;
        end
        idx = 0; cyc = 0; hold = 0; hold_d = '0;
        while (cyc < 20000 && !(done || end_err || pad_err)) begin
            @(negedge clk);
            cyc++;
            if (hold != 0) begin
                // R9: stalled byte held
                chk(out_valid && out_data == hold_d, "R9 stall hold", out_data, hold_d);
            end
            in_valid  = (idx < nbytes);
            in_data   = (idx < nbytes) ? stream[idx] : 8'h00;
            in_last   = (idx == nbytes - 1);
            out_ready = bp ? (cyc % 3 != 0) : 1'b1;
            #1;
            if (in_valid && in_ready) idx++;
            hold = 0;
            if (out_valid) begin
                if (out_ready) begin
                    if (ng < 1024) got_q[ng] = out_data;
                    ng++;
                end else begin
                    hold = 1;
                    hold_d = out_data;
                end
            end
        end
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0; out_ready = 1'b1;
    endtask

    task automatic cmp_out(input string tag);
        int bad, first;
        bad = 0; first = -1;
        chk(ng == ne, {tag, " output count"}, ng, ne);
        for (int i = 0; i < ne && i < ng; i++) begin
            if (got_q[i] !== exp_q[i]) begin
                bad++;
                if (first < 0) first = i;
            end
        end
        if (first >= 0) chk(1'b0, {tag, " output data"}, got_q[first], exp_q[first]);
        else            chk(1'b1, {tag, " output data"}, 0, 0);
    endtask

    task automatic t_reset();
        #1;
        // R11: reset state
        chk(!in_ready && !out_valid && !done && !end_err && !pad_err, "R11 reset state",
            {in_ready, out_valid, done, end_err, pad_err}, 0);
        repeat (100) @(negedge clk);
        chk(!in_ready, "R11 sweep holds input", in_ready, 0);
    endtask

    task automatic t_literals();
        begin_xfer();
        lit(8'h41); lit(8'h5A); lit(8'hFF); lit(8'h00); lit(8'h96);
        marker();
        run_stream(1'b0);
        cmp_out("R1 literals");
        chk(done && !end_err && !pad_err, "R6 done after marker", {done, end_err, pad_err}, 3'b100);
    endtask

    task automatic t_copy();
        begin_xfer();
        lit(1); lit(2); lit(3);
        cpy(3, 3); expect_byte(1); expect_byte(2); expect_byte(3);
        cpy(2, 2); expect_byte(2); expect_byte(3);
        marker();
        run_stream(1'b0);
        cmp_out("R2 copy");
        chk(done, "R2 done", done, 1);
    endtask

    task automatic t_overlap();
        begin_xfer();
        lit(7); lit(9);
        cpy(2, 5);
        expect_byte(7); expect_byte(9); expect_byte(7); expect_byte(9); expect_byte(7);
        cpy(1, 17);
        for (int i = 0; i < 17; i++) expect_byte(7);
        marker();
        run_stream(1'b1);
        cmp_out("R3 overlap with R9 backpressure");
        chk(done, "R3 done", done, 1);
    endtask

    task automatic t_clear();
        begin_xfer();
        cpy(5, 3); expect_byte(0); expect_byte(0); expect_byte(0);
        lit(8'hC3);
        cpy(300, 2); expect_byte(0); expect_byte(0);
        marker();
        run_stream(1'b0);
        cmp_out("R5 cleared history");
    endtask

    task automatic t_wrap();
        begin_xfer();
        lit(8'hA5);
        for (int k = 0; k < 30; k++) begin
            cpy(1, 17);
            for (int i = 0; i < 17; i++) expect_byte(8'hA5);
        end
        lit(8'hB4);
        lit(8'hC7);
        cpy(2, 2); expect_byte(8'hB4); expect_byte(8'hC7);
        marker();
        run_stream(1'b0);
        cmp_out("R4 wrap");
        chk(done, "R4 done", done, 1);
    endtask

    task automatic t_pad_zero_byte();
        begin_xfer();
        lit(8'h12);
        marker();
        put(0, 8);
        run_stream(1'b0);
        cmp_out("R6 extra zero padding");
        chk(done && !pad_err && !end_err, "R6 padding accepted", {done, end_err, pad_err}, 3'b100);
    endtask

    task automatic t_no_end();
        begin_xfer();
        lit(8'h3C); lit(8'h81);
        run_stream(1'b0);
        cmp_out("R7 missing marker");
        chk(end_err && !done, "R7 end error", {end_err, done}, 2'b10);
        repeat (6) @(negedge clk);
        #1;
        chk(end_err && !in_ready && !out_valid && !done, "R10 error sticky",
            {end_err, in_ready, out_valid, done}, 4'b1000);
    endtask

    task automatic t_pad_bad();
        begin_xfer();
        lit(8'h33);
        marker();
        put(0, 2); put(1, 1);
        run_stream(1'b0);
        cmp_out("R8 bad padding");
        chk(pad_err && !done && !end_err, "R8 pad error", {pad_err, done, end_err}, 3'b100);
        @(negedge clk); in_valid = 1'b1; in_data = 8'hFF;
        repeat (4) @(negedge clk);
        #1;
        chk(pad_err && !in_ready && !out_valid, "R10 input refused after error",
            {pad_err, in_ready, out_valid}, 3'b100);
        in_valid = 1'b0;
    endtask

    task automatic t_restart();
        begin_xfer();
        lit(8'h5E);
        marker();
        run_stream(1'b0);
        cmp_out("R11 restart after error");
        chk(done && !pad_err, "R11 flags cleared by start", {done, pad_err}, 2'b10);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_literals();
        t_copy();
        t_overlap();
        t_clear();
        t_wrap();
        t_pad_zero_byte();
        t_no_end();
        t_pad_bad();
        t_restart();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule